// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Register with Holding Stage

This block takes a serial bit stream and turns it into a parallel word. It has two register stages. The first is a shift chain clocked by a shift clock. The second is a holding register, clocked by a separate storage clock, that copies the whole chain at once. The parallel outputs come only from the holding register, so a new word can be shifted in while the previous word stays on the outputs.

Each stage has its own active-low clear. A clear forces its stage to zero as soon as it goes low. When the clear goes high again, the release is synchronised to that stage's own clock. The last shift stage also drives a cascade output. Several blocks can be chained by wiring that output to the next block's serial input, which makes a wider converter.

Bit 0 of the parallel word is the first stage (A), which receives the serial input. Bit WIDTH-1 is the last stage (H), which feeds the cascade output.

Top module: `sipo_dual_clock_latch`

## Requirements
- R1: While both clears are held low, every bit of `par_out` and `casc_out` reads 0, even if clock pulses arrive.
- R2: On a rising `sh_clk` edge of a running shift chain, stage 0 takes `ser_in` and stage k takes the old value of stage k-1. The falling `sh_clk` edge changes nothing.
- R3: `casc_out` always equals the last shift stage (bit WIDTH-1 of the chain), never the holding register. It therefore changes on shift edges while `par_out` stays the same.
- R4: A low `sh_clr_n` zeroes the shift chain at once, without waiting for a clock edge, and shift edges have no effect while it stays low.
- R5: On a rising `st_clk` edge of a running holding register, `par_out` takes the whole shift chain in parallel. Bit positions are kept.
- R6: A low `st_clr_n` zeroes `par_out` at once. It leaves the shift chain and `casc_out` untouched.
- R7: Clearing the shift chain does not change `par_out`. The next `st_clk` capture after the release loads the cleared (zero) chain.
- R8: When `sh_clk` and `st_clk` are the same signal, each edge captures the chain as it was before that edge's shift, so the holding register runs one pulse behind the chain.
- R9: After a clear goes high, the first SYNC_STAGES (default 2) rising edges of that stage's clock leave the stage at zero. The edge after them is the first to act.
- R10: With two blocks cascaded, 16 data shift edges followed by one storage edge leave the first block holding the last 8 bits shifted in and the second block holding the 8 bits before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| sh_clk | input | 1 | Shift chain clock, rising edge |
| sh_clr_n | input | 1 | Shift chain clear, active low, asynchronous assert |
| st_clk | input | 1 | Holding register clock, rising edge |
| st_clr_n | input | 1 | Holding register clear, active low, asynchronous assert |
| par_out | output | WIDTH | Holding register contents, bit 0 = first stage |
| casc_out | output | 1 | Last shift stage, for the next block's serial input |

## Verification
The test words are chosen so that a fault shows up in a specific way:
- A word with an uneven pattern, such as a run of ones after a clear, shows whether shifting has started on the correct edge.
- Words with an asymmetric bit pattern reveal any reversal of the shift direction or of the parallel bit order.
- Clearing one stage while the other holds data shows whether the two clears are independent.
- Tied-clock pulses on alternating data show the one-pulse lag between the chain and the holding register.
- Two blocks cascaded with two different bytes confirm that the cascade output comes from the chain and not from the holding register.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_DEF_WIDTH = 8;
  localparam int unsigned SIPO_DEF_SYNC  = 2;
endpackage

// File: rtl/sipo_clr_bridge.sv
module sipo_clr_bridge #(
  parameter int unsigned STAGES = sipo_pkg::SIPO_DEF_SYNC
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_multi
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [WIDTH-1:0] chain
);
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;
  logic             shift_en;

  assign shift_en = 1'b1;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[WIDTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign chain = chain_q;

  // R2: first stage loads serial input on a running edge
  p_stage_a_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> chain_q[0] == $past(din));
  // R2: every later stage takes its predecessor
  p_stage_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0]));
endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;
  logic             load_en;

  assign load_en = 1'b1;

  always_comb begin
    hold_d = hold_q;
    if (load_en) hold_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q = hold_q;

  // R5: a running storage edge copies the chain as sampled at that edge
  p_parallel_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> hold_q == $past(d));
endmodule

// File: rtl/sipo_dual_clock_latch.sv
module sipo_dual_clock_latch #(
  parameter int unsigned WIDTH       = sipo_pkg::SIPO_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = sipo_pkg::SIPO_DEF_SYNC
) (
  input  logic             ser_in,
  input  logic             sh_clk,
  input  logic             sh_clr_n,
  input  logic             st_clk,
  input  logic             st_clr_n,
  output logic [WIDTH-1:0] par_out,
  output logic             casc_out
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             sh_rst_n;
  logic             st_rst_n;
  logic [WIDTH-1:0] chain;

  sipo_clr_bridge #(.STAGES(SYNC_STAGES)) u_sh_bridge (
    .clk(sh_clk), .clr_n(sh_clr_n), .rst_n(sh_rst_n));

  sipo_clr_bridge #(.STAGES(SYNC_STAGES)) u_st_bridge (
    .clk(st_clk), .clr_n(st_clr_n), .rst_n(st_rst_n));

  sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(sh_clk), .rst_n(sh_rst_n), .din(ser_in), .chain(chain));

  sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk(st_clk), .rst_n(st_rst_n), .d(chain), .q(par_out));

  assign casc_out = chain[LAST];

  // R9: until the shift release reaches the chain, edges leave it at zero
  p_shift_release_hold_r9: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
    !sh_rst_n |-> chain == '0);
  // R9: until the storage release arrives, the outputs stay at zero
  p_store_release_hold_r9: assert property (@(posedge st_clk) disable iff (!st_clr_n)
    !st_rst_n |-> par_out == '0);
endmodule

// File: tb/sipo_dual_clock_latch_test.sv
module sipo_dual_clock_latch_test;
  localparam int W    = 8;
  localparam int SYNC = 2;

  logic ser_in, sh_clk, sh_clr_n, st_clk, st_clr_n;
  logic [W-1:0] par0, par1;
  logic casc0, casc1;

  sipo_dual_clock_latch #(.WIDTH(W), .SYNC_STAGES(SYNC)) uut (
    .ser_in(ser_in), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
    .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(par0), .casc_out(casc0));

  sipo_dual_clock_latch #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_tail (
    .ser_in(casc0), .sh_clk(sh_clk), .sh_clr_n(sh_clr_n),
    .st_clk(st_clk), .st_clr_n(st_clr_n), .par_out(par1), .casc_out(casc1));

  typedef struct packed {
    logic [W-1:0] p1;
    logic [W-1:0] p0;
    logic         c1;
    logic         c0;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  event  smp;
  int    n_chk, n_fail;
  bit    done;

  logic [2*W-1:0] m_chain;
  logic [W-1:0]   m_st0, m_st1;
  int             sh_wait, st_wait;

  function automatic obs_t model_obs();
    obs_t o;
    o.p1 = m_st1; o.p0 = m_st0; o.c1 = m_chain[2*W-1]; o.c0 = m_chain[W-1];
    return o;
  endfunction

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      obs_t e, a;
      string t;
      @(smp);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.p1 = par1; a.p0 = par0; a.c1 = casc1; a.c0 = casc0;
      n_chk++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic expect_now(string tag);
    exp_q.push_back(model_obs());
    tag_q.push_back(tag);
    ->smp;
    #1;
  endtask

  task automatic direct_chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sh_model();
    if (sh_clr_n) begin
      if (sh_wait > 0) sh_wait--;
      else m_chain = {m_chain[2*W-2:0], ser_in};
    end
  endtask

  task automatic st_model();
    if (st_clr_n) begin
      if (st_wait > 0) st_wait--;
      else {m_st1, m_st0} = m_chain;
    end
  endtask

  task automatic pulse(bit do_sh, bit do_st, bit d);
    ser_in = d;
    #5;
    if (do_st) st_model();
    if (do_sh) sh_model();
    sh_clk = do_sh; st_clk = do_st;
    #10;
    sh_clk = 1'b0; st_clk = 1'b0;
    #5;
  endtask

  task automatic shift_byte(logic [W-1:0] b);
    for (int i = W - 1; i >= 0; i--) pulse(1'b1, 1'b0, b[i]);
  endtask

  task automatic set_sh_clr(bit v);
    sh_clr_n = v;
    if (!v) begin m_chain = '0; sh_wait = SYNC; end
    #2;
  endtask

  task automatic set_st_clr(bit v);
    st_clr_n = v;
    if (!v) begin m_st0 = '0; m_st1 = '0; st_wait = SYNC; end
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    ser_in = 0; sh_clk = 0; st_clk = 0; sh_clr_n = 0; st_clr_n = 0;
    m_chain = '0; m_st0 = '0; m_st1 = '0; sh_wait = SYNC; st_wait = SYNC;
    #3;
    expect_now("R1 power-up with both clears low");
    pulse(1, 1, 1); pulse(1, 1, 1);
    expect_now("R4 clocks ignored while clears low");

    set_sh_clr(1); set_st_clr(1);
    for (int i = 0; i < SYNC; i++) pulse(1, 1, 1);
    expect_now("R9 release edges do not act");
    for (int i = 0; i < 6; i++) pulse(1, 0, 1);
    expect_now("R9 six ones after release, cascade still zero");
    pulse(0, 1, 0);
    expect_now("R5 capture of partial chain");

    for (int i = W - 1; i >= 1; i--) pulse(1, 0, (8'hA5 >> i) & 1'b1);
    ser_in = 1'b1; #5; sh_model(); sh_clk = 1'b1; #5;
    expect_now("R2 after rising edge of eighth bit");
    #5; sh_clk = 1'b0; #5;
    expect_now("R2 falling edge leaves chain unchanged");
    expect_now("R3 cascade follows chain while outputs hold");
    pulse(0, 1, 0);
    expect_now("R5 capture of A5 word");
    direct_chk("R5 stage order of A5 word", par0, 8'hA5);

    set_sh_clr(0);
    expect_now("R7 chain clear leaves outputs unchanged");
    set_sh_clr(1);
    pulse(0, 1, 0);
    expect_now("R7 next capture loads cleared chain");

    shift_byte(8'h96);
    pulse(0, 1, 0);
    expect_now("R5 capture after chain release");
    set_st_clr(0);
    expect_now("R6 storage clear zeroes outputs only");
    set_st_clr(1);
    for (int i = 0; i < SYNC; i++) pulse(0, 1, 0);
    expect_now("R9 storage release edges keep outputs zero");
    pulse(0, 1, 0);
    expect_now("R6 chain survived storage clear");

    for (int i = 0; i < 4; i++) begin
      pulse(1, 1, i[0]);
      expect_now("R8 tied clocks, storage one pulse behind");
    end

    set_sh_clr(0); set_st_clr(0);
    set_sh_clr(1); set_st_clr(1);
    for (int i = 0; i < SYNC; i++) pulse(1, 1, 1);
    shift_byte(8'h5A);
    shift_byte(8'hC3);
    pulse(0, 1, 0);
    expect_now("R10 cascaded pair after 16 shifts");
    direct_chk("R10 first block holds last byte", par0, 8'hC3);
    direct_chk("R10 second block holds earlier byte", par1, 8'h5A);

    #10;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule